// File: doc/BRIEF.md
# Socket Transmit Buffer Space Controller

This block keeps the books for the transmit memory of one network socket. The host never addresses that memory. It pushes 16-bit words through a single data port, and each accepted word lands at the current write pointer, which then moves on by two bytes and wraps at the configured buffer size. The host also programs a write-size register with the byte count of the next packet and then strobes SEND. The block subtracts that count from the free-size register and hands a base pointer and a length to the transmit engine. When the engine reports bytes as done, they are added back to the free size. The free size is therefore always an honest figure, and data that has not yet gone out is never overwritten.

The controller is a three-state machine. SK_INIT is entered on reset and lasts one cycle; in it the free size is loaded from the configured size and all host requests are ignored. Transition T_BOOT always goes from SK_INIT to SK_IDLE. SK_IDLE means that nothing is in flight, so the free size equals the configured size. SK_ACTIVE means that at least one accepted packet has not been fully reported as done. Transition T_LAUNCH goes from SK_IDLE to SK_ACTIVE when the next free size drops below the configured size. Transition T_DRAIN goes from SK_ACTIVE to SK_IDLE when the next free size is back at the configured size. In every other case the state holds.

A memory-test input lets the host read words back through the same port, from a separate read pointer. The engine fetches packet data through its own read port.

Top module: `sktx_buf_ctrl`

## Requirements
- R1: After reset and the one-cycle SK_INIT step, the outputs are as follows: free_size equals cfg_size, wr_size is 0, wr_ptr is 0, ovf_flag is 0, send_err is 0, tx_busy is 0, tx_go is 0 and fifo_rvalid is 0.
- R2: A write-size update (wsz_we) with a value no larger than cfg_size is loaded into wr_size on the next cycle. A larger value is ignored and wr_size keeps its old value.
- R3: A FIFO write that fits stores fifo_wdata at word index wr_ptr/2. It then advances wr_ptr by 2 bytes, and wr_ptr returns to 0 when it reaches cfg_size.
- R4: A FIFO write is accepted only when staged bytes plus 2 is no more than free_size. Otherwise the word is discarded, wr_ptr holds, and ovf_flag is set and stays set until reset.
- R5: A SEND with wr_size no larger than free_size is accepted, and the following happens on the next cycle. free_size drops by wr_size. tx_go pulses for one cycle. tx_base shows the send pointer, which starts at 0 and advances by each accepted length with wrap at cfg_size. tx_len shows wr_size. SENDs may be accepted back to back.
- R6: A SEND with wr_size larger than free_size is rejected: free_size does not change, tx_go stays low, and send_err is set and stays set until reset.
- R7: A tx_done pulse adds tx_done_bytes to free_size, clamped at cfg_size. tx_busy is high exactly when free_size is below cfg_size. A done pulse while idle leaves free_size at cfg_size.
- R8: With mem_test at 1, fifo_rd returns the word at the host read pointer on fifo_rdata, with fifo_rvalid high on the next cycle. The host read pointer then advances by 2 bytes and wraps at cfg_size. With mem_test at 0, fifo_rd is ignored: fifo_rvalid stays 0 and the read pointer does not move.
- R9: eng_rd returns the stored word at word index eng_addr on eng_rdata on the next cycle.
- R10: An accepted SEND removes wr_size bytes from the staged count, saturating at 0. This frees room for further writes within the reduced free size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | SZW | Configured buffer size in bytes (even, static outside reset) |
| mem_test | input | 1 | Memory-test mode; enables host read-back |
| fifo_wr | input | 1 | Host data-port write strobe |
| fifo_wdata | input | DW | Host write word |
| fifo_rd | input | 1 | Host data-port read strobe |
| fifo_rdata | output | DW | Host read-back word |
| fifo_rvalid | output | 1 | Read-back word valid |
| wsz_we | input | 1 | Write-size update strobe |
| wsz_wdata | input | SZW | New write-size value in bytes |
| wr_size | output | SZW | Current write-size register |
| free_size | output | SZW | Current free-size register |
| send | input | 1 | SEND command strobe |
| send_err | output | 1 | Sticky rejected-SEND flag |
| ovf_flag | output | 1 | Sticky discarded-write flag |
| tx_go | output | 1 | One-cycle packet launch pulse |
| tx_base | output | SZW | Byte pointer of launched packet |
| tx_len | output | SZW | Byte length of launched packet |
| tx_busy | output | 1 | Data in flight (state SK_ACTIVE) |
| tx_done | input | 1 | Engine completion pulse |
| tx_done_bytes | input | SZW | Bytes released by the completion |
| eng_rd | input | 1 | Engine memory read strobe |
| eng_addr | input | AW | Engine word address |
| eng_rdata | output | DW | Engine read word |
| wr_ptr | output | SZW | Host write byte pointer |

## Verification
The bench builds the block with MAX_BYTES at 32, so a buffer holds only 16 words. It first runs with cfg_size at 16 and then resets with cfg_size at 32, the full memory. With a buffer that short, every pointer wraps within a few writes. A full buffer, a rejected SEND while two packets are in flight, and the staged count being released by SEND all occur in short sequences. The second configuration takes the pointers and the free-size arithmetic to the top of their width.

// File: rtl/sktx_pkg.sv
package sktx_pkg;
    typedef enum logic [1:0] {
        SK_INIT   = 2'd0,
        SK_IDLE   = 2'd1,
        SK_ACTIVE = 2'd2
    } sk_state_e;
endpackage

// File: rtl/sktx_word_ram.sv
module sktx_word_ram #(
    parameter int DW    = 16,
    parameter int WORDS = 512,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_data,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_data
);
    logic [DW-1:0] mem [WORDS];

    // read-first: both read ports see the word as it was before this edge
    always_ff @(posedge clk) begin
        if (we)   mem[waddr] <= wdata;
        if (a_en) a_data     <= mem[a_addr];
        if (b_en) b_data     <= mem[b_addr];
    end
endmodule

// File: rtl/sktx_ptr_step.sv
module sktx_ptr_step #(
    parameter int SZW = 11
) (
    input  logic [SZW-1:0] cur,
    input  logic [SZW-1:0] inc,
    input  logic [SZW-1:0] lim,
    output logic [SZW-1:0] nxt
);
    logic [SZW:0] sum;
    logic [SZW:0] diff;

    always_comb begin
        sum  = {1'b0, cur} + {1'b0, inc};
        diff = sum - {1'b0, lim};
        nxt  = (sum >= {1'b0, lim}) ? diff[SZW-1:0] : sum[SZW-1:0];
    end
endmodule

// File: rtl/sktx_space_acct.sv
module sktx_space_acct #(
    parameter int SZW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           wr_acc,
    input  logic           send_acc,
    input  logic           done_acc,
    input  logic [SZW-1:0] cfg_size,
    input  logic [SZW-1:0] send_len,
    input  logic [SZW-1:0] done_bytes,
    output logic [SZW-1:0] free_size,
    output logic [SZW-1:0] staged,
    output logic [SZW-1:0] free_nxt
);
    logic [SZW:0]   f_sent;
    logic [SZW:0]   f_back;
    logic [SZW-1:0] st_w;
    logic [SZW-1:0] staged_nxt;

    always_comb begin
        f_sent = {1'b0, free_size} - (send_acc ? {1'b0, send_len} : '0);
        f_back = f_sent + (done_acc ? {1'b0, done_bytes} : '0);
        if (load)
            free_nxt = cfg_size;
        else if (f_back > {1'b0, cfg_size})
            free_nxt = cfg_size;
        else
            free_nxt = f_back[SZW-1:0];

        st_w = staged + (wr_acc ? SZW'(2) : '0);
        if (load)
            staged_nxt = '0;
        else if (send_acc)
            staged_nxt = (st_w > send_len) ? (st_w - send_len) : '0;
        else
            staged_nxt = st_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_size <= '0;
            staged    <= '0;
        end else begin
            free_size <= free_nxt;
            staged    <= staged_nxt;
        end
    end

    // R7: free space never reported above the configured size
    a_r7_free_capped: assert property (@(posedge clk) disable iff (!rst_n)
        free_size <= cfg_size);

    // R10: bytes staged by the host never exceed what is free
    a_r10_staged_in_free: assert property (@(posedge clk) disable iff (!rst_n)
        staged <= free_size);

    // R5: an accepted SEND without a completion lowers free space by its length
    a_r5_send_debits: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && send_acc && !done_acc) |=> (free_size == $past(free_size) - $past(send_len)));
endmodule

// File: rtl/sktx_buf_ctrl.sv
module sktx_buf_ctrl
    import sktx_pkg::*;
#(
    parameter int MAX_BYTES = 1024,
    parameter int DW        = 16,
    localparam int SZW      = $clog2(MAX_BYTES) + 1,
    localparam int WORDS    = MAX_BYTES / 2,
    localparam int AW       = $clog2(WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SZW-1:0] cfg_size,
    input  logic           mem_test,
    input  logic           fifo_wr,
    input  logic [DW-1:0]  fifo_wdata,
    input  logic           fifo_rd,
    output logic [DW-1:0]  fifo_rdata,
    output logic           fifo_rvalid,
    input  logic           wsz_we,
    input  logic [SZW-1:0] wsz_wdata,
    output logic [SZW-1:0] wr_size,
    output logic [SZW-1:0] free_size,
    input  logic           send,
    output logic           send_err,
    output logic           ovf_flag,
    output logic           tx_go,
    output logic [SZW-1:0] tx_base,
    output logic [SZW-1:0] tx_len,
    output logic           tx_busy,
    input  logic           tx_done,
    input  logic [SZW-1:0] tx_done_bytes,
    input  logic           eng_rd,
    input  logic [AW-1:0]  eng_addr,
    output logic [DW-1:0]  eng_rdata,
    output logic [SZW-1:0] wr_ptr
);
    localparam int NPTR = 3;   // 0: host write, 1: host read, 2: send
    localparam int PW   = 0;
    localparam int PR   = 1;
    localparam int PS   = 2;

    sk_state_e      state, state_n;
    logic           op;
    logic           wr_room, wr_acc, rd_acc, send_ok, send_rej, wsz_acc, done_acc;
    logic [SZW-1:0] staged, free_nxt;
    logic [SZW-1:0] ptr_cur [NPTR];
    logic [SZW-1:0] ptr_inc [NPTR];
    logic [SZW-1:0] ptr_nxt [NPTR];
    logic [NPTR-1:0] ptr_adv;
    logic [SZW-1:0] hrd_ptr, snd_ptr;

    // ---------------- request qualification ----------------
    always_comb begin
        op       = (state != SK_INIT);
        wr_room  = ({1'b0, staged} + (SZW+1)'(2)) <= {1'b0, free_size};
        wr_acc   = op && fifo_wr && wr_room;
        rd_acc   = op && fifo_rd && mem_test;
        send_ok  = op && send && (wr_size <= free_size);
        send_rej = op && send && !(wr_size <= free_size);
        wsz_acc  = op && wsz_we && (wsz_wdata <= cfg_size);
        done_acc = op && tx_done;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SK_INIT;
        else        state <= state_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            SK_INIT:   state_n = SK_IDLE;                                  // T_BOOT
            SK_IDLE:   if (free_nxt != cfg_size) state_n = SK_ACTIVE;      // T_LAUNCH
            SK_ACTIVE: if (free_nxt == cfg_size) state_n = SK_IDLE;        // T_DRAIN
            default:   state_n = SK_INIT;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_go       <= 1'b0;
            tx_base     <= '0;
            tx_len      <= '0;
            wr_size     <= '0;
            ovf_flag    <= 1'b0;
            send_err    <= 1'b0;
            fifo_rvalid <= 1'b0;
        end else begin
            tx_go       <= send_ok;
            fifo_rvalid <= rd_acc;
            if (send_ok) begin
                tx_base <= snd_ptr;
                tx_len  <= wr_size;
            end
            if (wsz_acc)                 wr_size  <= wsz_wdata;
            if (op && fifo_wr && !wr_room) ovf_flag <= 1'b1;
            if (send_rej)                send_err <= 1'b1;
        end
    end

    assign tx_busy = (state == SK_ACTIVE);

    // ---------------- pointers ----------------
    always_comb begin
        ptr_cur[PW] = wr_ptr;   ptr_inc[PW] = SZW'(2);  ptr_adv[PW] = wr_acc;
        ptr_cur[PR] = hrd_ptr;  ptr_inc[PR] = SZW'(2);  ptr_adv[PR] = rd_acc;
        ptr_cur[PS] = snd_ptr;  ptr_inc[PS] = wr_size;  ptr_adv[PS] = send_ok;
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        sktx_ptr_step #(.SZW(SZW)) u_step (
            .cur (ptr_cur[g]),
            .inc (ptr_inc[g]),
            .lim (cfg_size),
            .nxt (ptr_nxt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            hrd_ptr <= '0;
            snd_ptr <= '0;
        end else begin
            if (ptr_adv[PW]) wr_ptr  <= ptr_nxt[PW];
            if (ptr_adv[PR]) hrd_ptr <= ptr_nxt[PR];
            if (ptr_adv[PS]) snd_ptr <= ptr_nxt[PS];
        end
    end

    // ---------------- space accounting ----------------
    sktx_space_acct #(.SZW(SZW)) u_acct (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state == SK_INIT),
        .wr_acc     (wr_acc),
        .send_acc   (send_ok),
        .done_acc   (done_acc),
        .cfg_size   (cfg_size),
        .send_len   (wr_size),
        .done_bytes (tx_done_bytes),
        .free_size  (free_size),
        .staged     (staged),
        .free_nxt   (free_nxt)
    );

    // ---------------- storage ----------------
    sktx_word_ram #(.DW(DW), .WORDS(WORDS), .AW(AW)) u_ram (
        .clk    (clk),
        .we     (wr_acc),
        .waddr  (wr_ptr[SZW-2:1]),
        .wdata  (fifo_wdata),
        .a_en   (rd_acc),
        .a_addr (hrd_ptr[SZW-2:1]),
        .a_data (fifo_rdata),
        .b_en   (eng_rd),
        .b_addr (eng_addr),
        .b_data (eng_rdata)
    );

    // ---------------- assertions ----------------
    // R3: the write pointer always stays inside the configured buffer
    a_r3_wrptr_in_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SK_INIT) |-> (wr_ptr < cfg_size));

    // R4: a write with no room leaves the pointer alone and raises the flag
    a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (op && fifo_wr && !wr_room) |=> ($stable(wr_ptr) && ovf_flag));

    // R4: the overflow flag is sticky
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R6: the SEND error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        send_err |=> send_err);

    // R6: a rejected SEND launches nothing
    a_r6_reject_no_go: assert property (@(posedge clk) disable iff (!rst_n)
        send_rej |=> !tx_go);

    // R8: read-back data only follows a read in memory-test mode
    a_r8_rvalid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rvalid |-> $past(mem_test && fifo_rd));

    // R7: busy tracks free space below the configured size
    a_r7_busy_matches_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SK_INIT) |-> (tx_busy == (free_size != cfg_size)));
endmodule

// File: tb/sim_sktx_buf_ctrl.sv
module sim_sktx_buf_ctrl;
    localparam int MAXB = 32;
    localparam int DW   = 16;
    localparam int SZW  = $clog2(MAXB) + 1;
    localparam int AW   = $clog2(MAXB / 2);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [SZW-1:0] cfg_size = SZW'(16);
    logic           mem_test = 1'b0;
    logic           fifo_wr = 1'b0;
    logic [DW-1:0]  fifo_wdata = '0;
    logic           fifo_rd = 1'b0;
    logic [DW-1:0]  fifo_rdata;
    logic           fifo_rvalid;
    logic           wsz_we = 1'b0;
    logic [SZW-1:0] wsz_wdata = '0;
    logic [SZW-1:0] wr_size, free_size, tx_base, tx_len, wr_ptr;
    logic           send = 1'b0;
    logic           send_err, ovf_flag, tx_go, tx_busy;
    logic           tx_done = 1'b0;
    logic [SZW-1:0] tx_done_bytes = '0;
    logic           eng_rd = 1'b0;
    logic [AW-1:0]  eng_addr = '0;
    logic [DW-1:0]  eng_rdata;

    always #2 clk = ~clk;

    sktx_buf_ctrl #(.MAX_BYTES(MAXB), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .mem_test(mem_test),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_rvalid(fifo_rvalid),
        .wsz_we(wsz_we), .wsz_wdata(wsz_wdata), .wr_size(wr_size),
        .free_size(free_size), .send(send), .send_err(send_err),
        .ovf_flag(ovf_flag), .tx_go(tx_go), .tx_base(tx_base), .tx_len(tx_len),
        .tx_busy(tx_busy), .tx_done(tx_done), .tx_done_bytes(tx_done_bytes),
        .eng_rd(eng_rd), .eng_addr(eng_addr), .eng_rdata(eng_rdata),
        .wr_ptr(wr_ptr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // ---------------- behavioural reference ----------------
    int mem [int];
    bit m_init;
    int m_cfg, m_free, m_wsz, m_wp, m_hp, m_sp, m_staged;
    int m_base, m_len, m_rd, m_erd;
    bit m_ovf, m_err, m_go, m_rv, m_rk, m_ek;

    function automatic int wrapb(int p, int inc);
        int s = p + inc;
        return (s >= m_cfg) ? s - m_cfg : s;
    endfunction

    task automatic model_reset();
        mem.delete();
        m_init = 1; m_cfg = int'(cfg_size);
        m_free = 0; m_wsz = 0; m_wp = 0; m_hp = 0; m_sp = 0; m_staged = 0;
        m_base = 0; m_len = 0; m_rd = 0; m_erd = 0;
        m_ovf = 0; m_err = 0; m_go = 0; m_rv = 0; m_rk = 0; m_ek = 0;
    endtask

    task automatic model_edge();
        int old_free = m_free;
        int old_wsz  = m_wsz;
        int stw      = m_staged;
        if (eng_rd) begin
            if (mem.exists(int'(eng_addr))) begin m_erd = mem[int'(eng_addr)]; m_ek = 1; end
            else m_ek = 0;
        end
        if (m_init) begin
            m_free = m_cfg; m_init = 0; m_go = 0; m_rv = 0;
        end else begin
            m_go = 0; m_rv = 0;
            if (fifo_rd && mem_test) begin
                m_rv = 1;
                if (mem.exists(m_hp / 2)) begin m_rd = mem[m_hp / 2]; m_rk = 1; end
                else m_rk = 0;
                m_hp = wrapb(m_hp, 2);
            end
            if (fifo_wr) begin
                if (m_staged + 2 <= old_free) begin
                    mem[m_wp / 2] = int'(fifo_wdata);
                    m_wp = wrapb(m_wp, 2);
                    stw += 2;
                end else m_ovf = 1;
            end
            if (wsz_we && int'(wsz_wdata) <= m_cfg) m_wsz = int'(wsz_wdata);
            if (send) begin
                if (old_wsz <= old_free) begin
                    m_go = 1; m_base = m_sp; m_len = old_wsz;
                    m_free -= old_wsz;
                    m_sp = wrapb(m_sp, old_wsz);
                    stw = (stw > old_wsz) ? stw - old_wsz : 0;
                end else m_err = 1;
            end
            m_staged = stw;
            if (tx_done) begin
                m_free += int'(tx_done_bytes);
                if (m_free > m_cfg) m_free = m_cfg;
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", "wr_size", int'(wr_size), m_wsz);
        chk("R5", "free_size", int'(free_size), m_free);
        chk("R3", "wr_ptr", int'(wr_ptr), m_wp);
        chk("R4", "ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk("R6", "send_err", int'(send_err), int'(m_err));
        chk("R7", "tx_busy", int'(tx_busy), int'(m_free != m_cfg));
        chk("R5", "tx_go", int'(tx_go), int'(m_go));
        if (m_go) begin
            chk("R5", "tx_base", int'(tx_base), m_base);
            chk("R5", "tx_len", int'(tx_len), m_len);
        end
        chk("R8", "fifo_rvalid", int'(fifo_rvalid), int'(m_rv));
        if (m_rv && m_rk) chk("R8", "fifo_rdata", int'(fifo_rdata), m_rd);
        if (m_ek) chk("R9", "eng_rdata", int'(eng_rdata), m_erd);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        fifo_wr = 0; fifo_rd = 0; wsz_we = 0; send = 0; tx_done = 0; eng_rd = 0;
    endtask

    task automatic do_reset(input int cfg);
        @(negedge clk);
        rst_n = 0; cfg_size = SZW'(cfg);
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1;
        cyc();
    endtask

    task automatic put(input int d);
        fifo_wr = 1; fifo_wdata = DW'(d); cyc();
    endtask

    task automatic set_wsz(input int v);
        wsz_we = 1; wsz_wdata = SZW'(v); cyc();
    endtask

    task automatic do_send();
        send = 1; cyc();
    endtask

    task automatic done(input int b);
        tx_done = 1; tx_done_bytes = SZW'(b); cyc();
    endtask

    task automatic hread();
        fifo_rd = 1; cyc();
    endtask

    task automatic eread(input int a);
        eng_rd = 1; eng_addr = AW'(a); cyc();
    endtask

    initial begin
        // ======== configuration A: 16-byte buffer ========
        do_reset(16);
        chk("R1", "reset free", int'(free_size), 16);
        chk("R1", "reset wr_size", int'(wr_size), 0);
        chk("R1", "reset wr_ptr", int'(wr_ptr), 0);
        chk("R1", "reset flags", int'({ovf_flag, send_err, tx_busy, tx_go, fifo_rvalid}), 0);

        set_wsz(20);
        chk("R2", "oversize ignored", int'(wr_size), 0);
        set_wsz(8);
        chk("R2", "write size loaded", int'(wr_size), 8);

        for (int k = 0; k < 4; k++) put(16'hA000 + k);
        do_send();
        chk("R5", "launch pulse", int'(tx_go), 1);
        chk("R5", "free debited", int'(free_size), 8);

        for (int k = 0; k < 4; k++) put(16'hB000 + k);
        chk("R3", "pointer wrapped", int'(wr_ptr), 0);
        chk("R10", "staged released by send", int'(ovf_flag), 0);

        for (int k = 0; k < 8; k++) eread(k);

        do_send();
        chk("R5", "second base", int'(tx_base), 8);
        chk("R5", "buffer exhausted", int'(free_size), 0);

        put(16'hC000);
        chk("R4", "full write dropped ptr", int'(wr_ptr), 0);
        chk("R4", "overflow flagged", int'(ovf_flag), 1);

        do_send();
        chk("R6", "rejected send", int'(send_err), 1);
        chk("R6", "free unchanged", int'(free_size), 0);

        done(8);
        chk("R7", "partial restore busy", int'(tx_busy), 1);
        done(8);
        chk("R7", "drained", int'(tx_busy), 0);
        done(4);
        chk("R7", "idle done clamped", int'(free_size), 16);

        mem_test = 0;
        hread();
        chk("R8", "read ignored outside test", int'(fifo_rvalid), 0);
        mem_test = 1;
        hread();
        chk("R8", "first read-back", int'(fifo_rdata), 16'hA000);
        hread();
        hread();
        mem_test = 0;

        // ======== configuration B: full 32-byte buffer ========
        do_reset(32);
        chk("R1", "reset free B", int'(free_size), 32);
        set_wsz(33);
        chk("R2", "oversize ignored B", int'(wr_size), 0);
        for (int k = 0; k < 17; k++) put(16'h5000 + k);
        chk("R4", "seventeenth dropped", int'(ovf_flag), 1);
        chk("R3", "pointer wrapped B", int'(wr_ptr), 0);
        set_wsz(32);
        do_send();
        chk("R5", "full launch len", int'(tx_len), 32);
        done(12);
        done(20);
        chk("R7", "restored B", int'(free_size), 32);
        mem_test = 1;
        for (int k = 0; k < 17; k++) hread();
        chk("R8", "read pointer wrapped", int'(fifo_rdata), 16'h5000);
        mem_test = 0;
        eread(15);
        chk("R9", "last word", int'(eng_rdata), 16'h500F);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule